// File: doc/BRIEF.md
# Pipeline Operand Bypass Control

This block chooses the operand values for the execute and memory stages of a five-stage in-order integer pipeline. The pipeline stages are fetch, decode, execute, memory and writeback. The block receives:

- the source register numbers of the instruction in execute;
- the destination register and write-enable of the instructions in the memory and writeback stages;
- the opcode class of the memory-stage instruction.

From these it steers three multiplexers: ALU input A, ALU input B, and the store-data input of data memory. The block is purely combinational. It only selects values. Register file, ALU, memories and stall generation sit outside it.

There are three forwarding paths:

- **Memory to execute.** A dependent instruction can directly follow its producer with no gap cycle.
- **Writeback to execute.** A one-instruction gap between producer and consumer is covered.
- **Writeback to memory.** This path feeds only the store-data input of data memory, never its address. A store whose data register is written by the instruction just ahead of it still writes the fresh value.

A load followed by a store to the same address needs no forwarding, because both access data memory in the same stage.

Top module: `op_bypass_ctl`

## Requirements
- R1: The ALU A select reads 0 and ALU A carries the memory-stage ALU result when execute source 1 equals a valid memory-stage destination.
- R2: The ALU A select reads 1 and ALU A carries the writeback data when execute source 1 equals a valid writeback destination and not a valid memory-stage destination.
- R3: Otherwise the ALU A select reads 2 and ALU A carries the register-file value. The select never reads 3.
- R4: When both the memory and writeback producers match, the memory-stage (younger) value wins.
- R5: ALU B uses its own selector with the same 0/1/2 encoding, applied to execute source 2 and independent of source 1.
- R6: A producer whose write-enable is low never counts as a match. With only the writeback producer enabled and matching, the select falls to 1.
- R7: A destination of register 0 never counts as a match, even with write-enable high.
- R8: The store-data forward flag is 1 and store data carries the writeback data only when the memory-stage class is store (class code 2; ALU=0, load=1, other=3) and its data-source register equals a valid writeback destination.
- R9: In every other case the flag is 0 and store data carries the value latched in the memory stage. This includes non-store classes with a matching register, a disabled writeback producer, and register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src1 | input | 5 | Execute-stage source register 1 |
| ex_src2 | input | 5 | Execute-stage source register 2 |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage register write-enable |
| mem_cls | input | 2 | Memory-stage opcode class (0 ALU, 1 load, 2 store, 3 other) |
| mem_st_src | input | 5 | Memory-stage store-data source register |
| wb_dst | input | 5 | Writeback-stage destination register |
| wb_wen | input | 1 | Writeback-stage register write-enable |
| ex_rf_a | input | 32 | Register-file value for source 1, latched in execute |
| ex_rf_b | input | 32 | Register-file value for source 2, latched in execute |
| mem_alu_res | input | 32 | ALU result latched in the memory stage |
| mem_st_val | input | 32 | Store data latched in the memory stage |
| wb_val | input | 32 | Selected writeback data |
| alu_a | output | 32 | Selected ALU input A |
| alu_b | output | 32 | Selected ALU input B |
| alu_a_sel | output | 2 | ALU A select (0 memory, 1 writeback, 2 register file) |
| alu_b_sel | output | 2 | ALU B select (0 memory, 1 writeback, 2 register file) |
| st_data | output | 32 | Store data to data memory |
| st_fwd | output | 1 | Store data forwarded from writeback |

## Verification
The hardest situations are the ones where a producer looks like a match but must be rejected:

- a register-0 destination with write-enable high;
- a disabled memory-stage producer hiding an enabled writeback producer of the same register;
- both stages naming the same register at once.

The vector table places each of these on one or both operands, with every data input holding a distinct pattern, so a wrong choice shows up as a wrong value. Directed store cases then give a non-store class the same matching registers that force a forward when the class is store.

// File: rtl/byp_pkg.sv
package byp_pkg;
  typedef enum logic [1:0] {
    SRC_MEM = 2'd0,
    SRC_WB  = 2'd1,
    SRC_RF  = 2'd2
  } byp_src_e;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_OTHER = 2'd3
  } op_cls_e;
endpackage

// File: rtl/byp_hit.sv
module byp_hit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);
  function automatic logic dest_hit(input logic [REG_W-1:0] s,
                                    input logic [REG_W-1:0] d,
                                    input logic w);
    return w && (d != '0) && (s == d);
  endfunction

  assign hit = dest_hit(src, dst, wen);

  always_comb begin
    // R7
    zero_dst_chk: assert (!(hit && dst == '0));
    // R6
    wen_low_chk: assert (!(hit && !wen));
  end
endmodule

// File: rtl/byp_opnd_mux.sv
module byp_opnd_mux
  import byp_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_wen,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_wen,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output byp_src_e          sel,
  output logic [DATA_W-1:0] val
);
  logic hit_mem;
  logic hit_wb;

  byp_hit #(.REG_W(REG_W)) u_hit_mem (
    .src(src), .dst(mem_dst), .wen(mem_wen), .hit(hit_mem));
  byp_hit #(.REG_W(REG_W)) u_hit_wb (
    .src(src), .dst(wb_dst), .wen(wb_wen), .hit(hit_wb));

  always_comb begin
    if (hit_mem)     sel = SRC_MEM;
    else if (hit_wb) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  always_comb begin
    unique case (sel)
      SRC_MEM: val = mem_val;
      SRC_WB:  val = wb_val;
      default: val = rf_val;
    endcase
  end

  always_comb begin
    // R4
    mem_prio_chk: assert (!(hit_mem && hit_wb) || sel == SRC_MEM);
    // R3
    sel_range_chk: assert (sel != 2'd3);
    // R7
    zero_src_chk: assert (src != '0 || sel == SRC_RF);
    // R3
    rf_pass_chk: assert (sel != SRC_RF || val == rf_val);
  end
endmodule

// File: rtl/byp_store_mux.sv
module byp_store_mux
  import byp_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  op_cls_e           cls,
  input  logic [REG_W-1:0]  st_src,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_wen,
  input  logic [DATA_W-1:0] st_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic              fwd,
  output logic [DATA_W-1:0] data
);
  logic hit_wb;

  byp_hit #(.REG_W(REG_W)) u_hit (
    .src(st_src), .dst(wb_dst), .wen(wb_wen), .hit(hit_wb));

  assign fwd  = (cls == CLS_STORE) && hit_wb;
  assign data = fwd ? wb_val : st_val;

  always_comb begin
    // R9
    non_store_chk: assert (cls == CLS_STORE || !fwd);
    // R9
    keep_latched_chk: assert (fwd || data == st_val);
  end
endmodule

// File: rtl/op_bypass_ctl.sv
module op_bypass_ctl
  import byp_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  ex_src1,
  input  logic [REG_W-1:0]  ex_src2,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_wen,
  input  logic [1:0]        mem_cls,
  input  logic [REG_W-1:0]  mem_st_src,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic              wb_wen,
  input  logic [DATA_W-1:0] ex_rf_a,
  input  logic [DATA_W-1:0] ex_rf_b,
  input  logic [DATA_W-1:0] mem_alu_res,
  input  logic [DATA_W-1:0] mem_st_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  output logic [1:0]        alu_a_sel,
  output logic [1:0]        alu_b_sel,
  output logic [DATA_W-1:0] st_data,
  output logic              st_fwd
);
  localparam int NUM_OPND = 2;

  logic [REG_W-1:0]  opnd_src [NUM_OPND];
  logic [DATA_W-1:0] opnd_rf  [NUM_OPND];
  logic [DATA_W-1:0] opnd_val [NUM_OPND];
  byp_src_e          opnd_sel [NUM_OPND];

  assign opnd_src[0] = ex_src1;
  assign opnd_src[1] = ex_src2;
  assign opnd_rf[0]  = ex_rf_a;
  assign opnd_rf[1]  = ex_rf_b;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    byp_opnd_mux #(.REG_W(REG_W), .DATA_W(DATA_W)) u_mux (
      .src     (opnd_src[g]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .rf_val  (opnd_rf[g]),
      .mem_val (mem_alu_res),
      .wb_val  (wb_val),
      .sel     (opnd_sel[g]),
      .val     (opnd_val[g])
    );
  end

  assign alu_a     = opnd_val[0];
  assign alu_b     = opnd_val[1];
  assign alu_a_sel = opnd_sel[0];
  assign alu_b_sel = opnd_sel[1];

  byp_store_mux #(.REG_W(REG_W), .DATA_W(DATA_W)) u_st (
    .cls    (op_cls_e'(mem_cls)),
    .st_src (mem_st_src),
    .wb_dst (wb_dst),
    .wb_wen (wb_wen),
    .st_val (mem_st_val),
    .wb_val (wb_val),
    .fwd    (st_fwd),
    .data   (st_data)
  );

  always_comb begin
    // R5
    same_src_chk: assert (ex_src1 != ex_src2 || alu_a_sel == alu_b_sel);
    // R1
    mem_val_chk: assert (alu_a_sel != 2'd0 || alu_a == mem_alu_res);
  end
endmodule

// File: tb/sim_op_bypass_ctl.sv
module sim_op_bypass_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  ex_src1, ex_src2, mem_dst, mem_st_src, wb_dst;
  logic        mem_wen, wb_wen, st_fwd;
  logic [1:0]  mem_cls, alu_a_sel, alu_b_sel;
  logic [31:0] ex_rf_a, ex_rf_b, mem_alu_res, mem_st_val, wb_val;
  logic [31:0] alu_a, alu_b, st_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  op_bypass_ctl u0 (.*);

  localparam logic [31:0] V_RFA = 32'hA1A1_0001;
  localparam logic [31:0] V_RFB = 32'hB2B2_0002;
  localparam logic [31:0] V_MEM = 32'hC3C3_0003;
  localparam logic [31:0] V_WB  = 32'hD4D4_0004;
  localparam logic [31:0] V_ST  = 32'hE5E5_0005;

  // {src1, src2, mem_dst, mem_wen, wb_dst, wb_wen, exp_sel_a, exp_sel_b}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd4,  1'b1, 2'd0, 2'd1}, // R1 R2 R5
    {5'd3,  5'd4,  5'd4,  1'b1, 5'd3,  1'b1, 2'd1, 2'd0}, // R5
    {5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'd0, 2'd0}, // R4
    {5'd6,  5'd7,  5'd6,  1'b0, 5'd7,  1'b0, 2'd2, 2'd2}, // R6
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'd2, 2'd2}, // R7
    {5'd8,  5'd9,  5'd1,  1'b1, 5'd2,  1'b1, 2'd2, 2'd2}, // R3
    {5'd10, 5'd10, 5'd11, 1'b1, 5'd10, 1'b1, 2'd1, 2'd1}, // R2
    {5'd12, 5'd13, 5'd12, 1'b0, 5'd12, 1'b1, 2'd1, 2'd2}, // R6
    {5'd31, 5'd31, 5'd31, 1'b1, 5'd0,  1'b1, 2'd0, 2'd0}, // R1
    {5'd0,  5'd14, 5'd0,  1'b1, 5'd14, 1'b1, 2'd2, 2'd1}  // R7
  };

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
    case (s)
      2'd0:    return V_MEM;
      2'd1:    return V_WB;
      default: return rf;
    endcase
  endfunction

  task automatic store_case(input logic [1:0] cls, input logic [4:0] src,
                            input logic [4:0] dst, input logic wen,
                            input logic exp_fwd, input string req);
    @(negedge clk);
    mem_cls = cls; mem_st_src = src; wb_dst = dst; wb_wen = wen;
    #1;
    chk(st_fwd == exp_fwd, req, {31'd0, st_fwd}, {31'd0, exp_fwd});
    chk(st_data == (exp_fwd ? V_WB : V_ST), req, st_data, exp_fwd ? V_WB : V_ST);
  endtask

  initial begin
    ex_src1 = '0; ex_src2 = '0; mem_dst = '0; mem_wen = 1'b0; mem_cls = 2'd0;
    mem_st_src = '0; wb_dst = '0; wb_wen = 1'b0;
    ex_rf_a = V_RFA; ex_rf_b = V_RFB; mem_alu_res = V_MEM;
    mem_st_val = V_ST; wb_val = V_WB;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R3: quiet state selects register file
    chk(alu_a_sel == 2'd2, "R3", {30'd0, alu_a_sel}, 32'd2);
    chk(alu_b == V_RFB, "R3", alu_b, V_RFB);
    chk(st_fwd == 1'b0, "R9", {31'd0, st_fwd}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] ea, eb;
      @(negedge clk);
      {ex_src1, ex_src2, mem_dst, mem_wen, wb_dst, wb_wen, ea, eb} = VEC[i];
      #1;
      chk(alu_a_sel == ea, "R1 R2 R3 R4 R6 R7 (A)", {30'd0, alu_a_sel}, {30'd0, ea});
      chk(alu_b_sel == eb, "R5 (B)", {30'd0, alu_b_sel}, {30'd0, eb});
      chk(alu_a == pick(ea, V_RFA), "R1 R2 R3 (A value)", alu_a, pick(ea, V_RFA));
      chk(alu_b == pick(eb, V_RFB), "R5 (B value)", alu_b, pick(eb, V_RFB));
    end

    // R8 store forwarding, class codes 0 ALU 1 load 2 store 3 other
    store_case(2'd2, 5'd7, 5'd7, 1'b1, 1'b1, "R8");
    store_case(2'd2, 5'd31, 5'd31, 1'b1, 1'b1, "R8");
    // R9 cases left on the latched value
    store_case(2'd0, 5'd7, 5'd7, 1'b1, 1'b0, "R9 alu class");
    store_case(2'd1, 5'd7, 5'd7, 1'b1, 1'b0, "R9 load class");
    store_case(2'd3, 5'd7, 5'd7, 1'b1, 1'b0, "R9 other class");
    store_case(2'd2, 5'd7, 5'd7, 1'b0, 1'b0, "R9 wen low");
    store_case(2'd2, 5'd0, 5'd0, 1'b1, 1'b0, "R9 reg zero");
    store_case(2'd2, 5'd7, 5'd8, 1'b1, 1'b0, "R9 mismatch");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule